// File: doc/BRIEF.md
# Serial Configuration Image Loader

This block pushes a stored configuration image into a downstream programmable device through a slave-serial link. The image arrives byte by byte from a byte source with a valid/ready handshake and a last-byte flag. Each byte is sent out unchanged, one bit at a time, on a single data line. The loader generates the configuration clock itself. No byte of the image is removed or altered, so a file header may stay in the stream.

A load begins with a one-cycle start pulse. The loader first drives the device's program line low for a fixed time. It then waits until the device releases its init line, and only after that does it stream the data. After the last byte it keeps producing clock edges, with the data line held, until the device raises its done line. The load ends in one of three results: success, an init-line failure (reported as a CRC error), or a timeout. A load can never hang. The bit order within a byte is chosen per load, so both orders can be tried on the same stored data.

Top module: `cfg_serial_loader`

## Requirements
- R1: Out of reset, cfg_prog_n is 1, cfg_cclk is 0, src_ready is 0, and busy, done_ok, crc_error and timeout are all 0.
- R2: A start pulse drives cfg_prog_n low for exactly PROG_CYCLES clock cycles. No rising edge of cfg_cclk occurs before cfg_init_n is high. If cfg_init_n is still low INIT_WAIT cycles after cfg_prog_n is released, the load ends with timeout.
- R3: Every byte the source supplies is sent unchanged. With msb_first=0 (sampled at start), bit 0 goes out on the first rising edge of cfg_cclk and bit 7 on the eighth. With msb_first=1 the order is bit 7 first, down to bit 0.
- R4: cfg_din changes only while cfg_cclk is low. cfg_cclk stays low for CLK_DIV/2 clock cycles and high for CLK_DIV-CLK_DIV/2 clock cycles.
- R5: src_ready is high only between bytes, while cfg_cclk is low. The n-th byte (counting from 0) is accepted only after 8·n rising edges of cfg_cclk.
- R6: After the byte flagged last, cfg_cclk keeps toggling with cfg_din held at the last data bit. Once cfg_done is seen high, the load ends with done_ok.
- R7: cfg_init_n going low after data transfer has begun aborts the load and raises crc_error.
- R8: If cfg_done is still low after exactly TAIL_EDGES rising edges following the data, the load ends with timeout.
- R9: At most one of busy, done_ok, crc_error and timeout is high at any time. A result is held until the next start, and a start pulse while busy is ignored.
- R10: busy rises only in the cycle after a start pulse and stays high until the result is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a load |
| msb_first | input | 1 | Bit order for the load: 0 sends LSB first, 1 sends MSB first |
| src_data | input | DATA_W | Image byte from the byte source |
| src_valid | input | 1 | src_data holds a byte |
| src_last | input | 1 | The offered byte is the final byte of the image |
| src_ready | output | 1 | Loader accepts a byte in this cycle |
| cfg_prog_n | output | 1 | Active-low program line to the device |
| cfg_cclk | output | 1 | Configuration clock to the device |
| cfg_din | output | 1 | Serial configuration data |
| cfg_init_n | input | 1 | Device init line (low means clearing or error) |
| cfg_done | input | 1 | Device done line |
| busy | output | 1 | Load in progress |
| done_ok | output | 1 | Last load completed with done seen |
| crc_error | output | 1 | Last load aborted by init going low |
| timeout | output | 1 | Last load ended without init release or done |

## Verification
A wrong bit counter or a wrong shift direction shows up at the ports as a mismatched bit on the next rising edge of cfg_cclk, within eight edges of the fault. It also shows up as a byte accepted at a rising-edge count that is not a multiple of eight. A divider fault shows as a high phase of the wrong length, or as cfg_din moving while cfg_cclk is high, within one configuration clock period. A fault in the control state shows as a wrong or missing result within a few cycles of the init or done event that triggers it. The tail counter is checked by counting the exact number of extra rising edges before timeout.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_WINIT,
    ST_LOAD,
    ST_SHIFT,
    ST_TAIL
  } cfgl_state_e;

  typedef enum logic [1:0] {
    RES_NONE,
    RES_OK,
    RES_CRC,
    RES_TMO
  } cfgl_res_e;

endpackage

// File: rtl/cfgl_sync.sv
module cfgl_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/cfgl_clkgen.sv
module cfgl_clkgen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic cclk,
  output logic rise_evt,
  output logic fall_evt
);

  localparam int LOW_CYC = DIV / 2;
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cclk_q, cclk_d;

  // cclk goes high after cnt==LOW_CYC-1 and low again after cnt==DIV-1
  assign rise_evt = en && (cnt_q == CW'(LOW_CYC - 1));
  assign fall_evt = en && (cnt_q == CW'(DIV - 1));

  always_comb begin
    cnt_d  = cnt_q;
    cclk_d = cclk_q;
    if (!en) begin
      cnt_d  = '0;
      cclk_d = 1'b0;
    end else if (fall_evt) begin
      cnt_d  = '0;
      cclk_d = 1'b0;
    end else begin
      cnt_d = cnt_q + 1'b1;
      if (rise_evt) cclk_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      cclk_q <= cclk_d;
    end
  end

  assign cclk = cclk_q;

endmodule

// File: rtl/cfgl_shifter.sv
module cfgl_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_order,
  input  logic              order_msb,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  logic              shift,
  output logic              din
);

  logic              ord_q, ord_d;
  logic [DATA_W-1:0] sreg_q, sreg_d;

  always_comb begin
    ord_d  = set_order ? order_msb : ord_q;
    sreg_d = sreg_q;
    if (load) begin
      sreg_d = data;
    end else if (shift) begin
      sreg_d = ord_q ? {sreg_q[DATA_W-2:0], 1'b0} : {1'b0, sreg_q[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ord_q  <= 1'b0;
      sreg_q <= '0;
    end else begin
      ord_q  <= ord_d;
      sreg_q <= sreg_d;
    end
  end

  assign din = ord_q ? sreg_q[DATA_W-1] : sreg_q[0];

endmodule

// File: rtl/cfgl_ctrl.sv
module cfgl_ctrl
  import cfgl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PROG_CYCLES = 16,
  parameter int INIT_WAIT = 4096,
  parameter int TAIL_EDGES = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic src_valid,
  input  logic src_last,
  input  logic init_ok,
  input  logic done_s,
  input  logic rise_evt,
  input  logic fall_evt,
  output logic src_ready,
  output logic prog_n,
  output logic clk_en,
  output logic set_order,
  output logic load,
  output logic shift,
  output logic busy,
  output logic done_ok,
  output logic crc_error,
  output logic timeout
);

  localparam int MAX_A = (PROG_CYCLES > INIT_WAIT) ? PROG_CYCLES : INIT_WAIT;
  localparam int CNT_MAX = (MAX_A > TAIL_EDGES) ? MAX_A : TAIL_EDGES;
  localparam int CW = $clog2(CNT_MAX + 1);
  localparam int BW = $clog2(DATA_W);

  cfgl_state_e   state_q, state_d;
  cfgl_res_e     res_q, res_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          last_q, last_d;

  always_comb begin
    state_d   = state_q;
    res_d     = res_q;
    cnt_d     = cnt_q;
    bit_d     = bit_q;
    last_d    = last_q;
    set_order = 1'b0;
    load      = 1'b0;
    shift     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d   = ST_PROG;
          res_d     = RES_NONE;
          cnt_d     = '0;
          set_order = 1'b1;
        end
      end
      ST_PROG: begin
        if (cnt_q == CW'(PROG_CYCLES - 1)) begin
          state_d = ST_WINIT;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_WINIT: begin
        if (init_ok) begin
          state_d = ST_LOAD;
        end else if (cnt_q == CW'(INIT_WAIT - 1)) begin
          state_d = ST_IDLE;
          res_d   = RES_TMO;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_LOAD: begin
        if (!init_ok) begin
          state_d = ST_IDLE;
          res_d   = RES_CRC;
        end else if (src_valid) begin
          state_d = ST_SHIFT;
          load    = 1'b1;
          bit_d   = '0;
          last_d  = src_last;
        end
      end
      ST_SHIFT: begin
        if (!init_ok) begin
          state_d = ST_IDLE;
          res_d   = RES_CRC;
        end else if (fall_evt) begin
          if (bit_q == BW'(DATA_W - 1)) begin
            cnt_d   = '0;
            state_d = last_q ? ST_TAIL : ST_LOAD;
          end else begin
            bit_d = bit_q + 1'b1;
            shift = 1'b1;
          end
        end
      end
      ST_TAIL: begin
        if (!init_ok) begin
          state_d = ST_IDLE;
          res_d   = RES_CRC;
        end else if (fall_evt) begin
          if (done_s) begin
            state_d = ST_IDLE;
            res_d   = RES_OK;
          end else if (cnt_q == CW'(TAIL_EDGES)) begin
            state_d = ST_IDLE;
            res_d   = RES_TMO;
          end
        end else if (rise_evt) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      res_q   <= RES_NONE;
      cnt_q   <= '0;
      bit_q   <= '0;
      last_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      res_q   <= res_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      last_q  <= last_d;
    end
  end

  assign src_ready = (state_q == ST_LOAD) && init_ok;
  assign prog_n    = (state_q != ST_PROG);
  assign clk_en    = (state_q == ST_SHIFT) || (state_q == ST_TAIL);
  assign busy      = (state_q != ST_IDLE);
  assign done_ok   = (res_q == RES_OK);
  assign crc_error = (res_q == RES_CRC);
  assign timeout   = (res_q == RES_TMO);

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader #(
  parameter int DATA_W = 8,
  parameter int CLK_DIV = 4,
  parameter int PROG_CYCLES = 16,
  parameter int INIT_WAIT = 4096,
  parameter int TAIL_EDGES = 512,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              msb_first,
  input  logic [DATA_W-1:0] src_data,
  input  logic              src_valid,
  input  logic              src_last,
  output logic              src_ready,
  output logic              cfg_prog_n,
  output logic              cfg_cclk,
  output logic              cfg_din,
  input  logic              cfg_init_n,
  input  logic              cfg_done,
  output logic              busy,
  output logic              done_ok,
  output logic              crc_error,
  output logic              timeout
);

  logic [1:0] stat_s;
  logic       clk_en, rise_evt, fall_evt;
  logic       set_order, load, shift;

  cfgl_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cfg_done, cfg_init_n}),
    .q     (stat_s)
  );

  cfgl_clkgen #(.DIV(CLK_DIV)) i_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (clk_en),
    .cclk     (cfg_cclk),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  cfgl_shifter #(.DATA_W(DATA_W)) i_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_order (set_order),
    .order_msb (msb_first),
    .load      (load),
    .data      (src_data),
    .shift     (shift),
    .din       (cfg_din)
  );

  cfgl_ctrl #(
    .DATA_W      (DATA_W),
    .PROG_CYCLES (PROG_CYCLES),
    .INIT_WAIT   (INIT_WAIT),
    .TAIL_EDGES  (TAIL_EDGES)
  ) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .src_valid (src_valid),
    .src_last  (src_last),
    .init_ok   (stat_s[0]),
    .done_s    (stat_s[1]),
    .rise_evt  (rise_evt),
    .fall_evt  (fall_evt),
    .src_ready (src_ready),
    .prog_n    (cfg_prog_n),
    .clk_en    (clk_en),
    .set_order (set_order),
    .load      (load),
    .shift     (shift),
    .busy      (busy),
    .done_ok   (done_ok),
    .crc_error (crc_error),
    .timeout   (timeout)
  );

endmodule

// File: rtl/cfgl_loader_chk.sv
module cfgl_loader_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              msb_first,
  input logic [DATA_W-1:0] src_data,
  input logic              src_valid,
  input logic              src_ready,
  input logic              cfg_prog_n,
  input logic              cfg_cclk,
  input logic              cfg_din,
  input logic              busy,
  input logic              done_ok,
  input logic              crc_error,
  input logic              timeout
);

  // R9
  status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, done_ok, crc_error, timeout}));

  // R9
  ok_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ok && !start) |=> done_ok);

  // R4
  din_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_cclk |-> $stable(cfg_din));

  // R5
  ready_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> (!cfg_cclk && busy));

  // R3
  first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && src_ready) |=>
      (cfg_din == ($past(msb_first) ? $past(src_data[DATA_W-1]) : $past(src_data[0]))));

  // R2
  prog_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_prog_n |-> (!cfg_cclk && !src_ready));

  // R10
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

endmodule

bind cfg_serial_loader cfgl_loader_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_cfg_serial_loader.sv
module test_cfg_serial_loader;

  localparam time CLK_PERIOD = 10ns;
  localparam int DIV = 4;
  localparam int PROG = 8;
  localparam int IWAIT = 200;
  localparam int TAIL = 16;
  localparam int HI_LEN = DIV - DIV / 2;

  logic       clk, rst_n, start, msb_first;
  logic [7:0] src_data;
  logic       src_valid, src_last, src_ready;
  logic       cfg_prog_n, cfg_cclk, cfg_din, cfg_init_n, cfg_done;
  logic       busy, done_ok, crc_error, timeout;

  cfg_serial_loader #(
    .DATA_W(8), .CLK_DIV(DIV), .PROG_CYCLES(PROG),
    .INIT_WAIT(IWAIT), .TAIL_EDGES(TAIL), .SYNC_STAGES(2)
  ) i_cfg_serial_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .msb_first(msb_first),
    .src_data(src_data), .src_valid(src_valid), .src_last(src_last),
    .src_ready(src_ready), .cfg_prog_n(cfg_prog_n), .cfg_cclk(cfg_cclk),
    .cfg_din(cfg_din), .cfg_init_n(cfg_init_n), .cfg_done(cfg_done),
    .busy(busy), .done_ok(done_ok), .crc_error(crc_error), .timeout(timeout)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  // scoreboard and device model state
  bit exp_q[$];
  int rises, tail_rises, bad_rise, tail_bad, hi_bad, hi_len;
  int prog_len, last_prog, prog_falls, rel_cnt, rdy_seen;
  int crc_at, done_after;
  bit hold_init, crc_hit, done_hit, last_bit, prev_prog;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: compare each sampled bit against the scoreboard
  always @(posedge cfg_cclk) begin
    rises++;
    if (!cfg_init_n && crc_at == 0) bad_rise++;
    if (exp_q.size() > 0) begin
      bit e;
      e = exp_q.pop_front();
      last_bit = e;
      n_chk++;
      if (cfg_din !== e) begin
        n_err++;
        $display("FAIL R3: bit %0d actual %0d expected %0d", rises, cfg_din, e);
      end
    end else begin
      tail_rises++;
      if (cfg_din !== last_bit) tail_bad++;
      if (done_after >= 0 && tail_rises >= done_after) done_hit = 1'b1;
    end
    if (crc_at > 0 && rises == crc_at) crc_hit = 1'b1;
  end

  // device status lines and port observers, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (!cfg_prog_n) begin
        if (prev_prog) prog_falls++;
        prog_len++;
        cfg_init_n <= 1'b0;
        cfg_done   <= 1'b0;
        rel_cnt = 5;
      end else begin
        if (prog_len != 0) begin
          last_prog = prog_len;
          prog_len = 0;
        end
        if (rel_cnt > 0) begin
          rel_cnt--;
          if (rel_cnt == 0 && !hold_init) cfg_init_n <= 1'b1;
        end
      end
      if (crc_hit) cfg_init_n <= 1'b0;
      if (done_hit) cfg_done <= 1'b1;
      if (src_ready) rdy_seen++;
      if (cfg_cclk) hi_len++;
      else if (hi_len != 0) begin
        if (hi_len != HI_LEN) hi_bad++;
        hi_len = 0;
      end
      prev_prog = cfg_prog_n;
    end
  end

  task automatic begin_load(input bit order, input bit hold, input int crc, input int dafter);
    exp_q.delete();
    rises = 0; tail_rises = 0; bad_rise = 0; tail_bad = 0; hi_bad = 0;
    prog_falls = 0; rdy_seen = 0;
    crc_at = crc; done_after = dafter; hold_init = hold;
    crc_hit = 1'b0; done_hit = 1'b0;
    @(negedge clk);
    msb_first = order;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // driver: pushes the expected bits, then offers the byte
  task automatic send_byte(input logic [7:0] b, input bit last, input int idx, input bit order);
    for (int i = 0; i < 8; i++) exp_q.push_back(order ? b[7-i] : b[i]);
    src_data  = b;
    src_last  = last;
    src_valid = 1'b1;
    while (!src_ready) @(negedge clk);
    // R5: byte idx accepted only after 8*idx rising edges
    check(rises == 8 * idx, "R5 accept point", rises, 8 * idx);
    @(negedge clk);
    src_valid = 1'b0;
    src_last  = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; msb_first = 1'b0;
    src_data = '0; src_valid = 1'b0; src_last = 1'b0;
    cfg_init_n = 1'b1; cfg_done = 1'b0;
    crc_at = 0; done_after = -1; hold_init = 1'b0; prev_prog = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cfg_prog_n == 1 && cfg_cclk == 0 && src_ready == 0, "R1 pins", {cfg_prog_n, cfg_cclk, src_ready}, 3'b100);
    check({busy, done_ok, crc_error, timeout} == 4'b0, "R1 status", {busy, done_ok, crc_error, timeout}, 0);

    // LSB first, done after 3 tail edges, extra start while busy
    begin_load(1'b0, 1'b0, 0, 3);
    check(busy == 1, "R10 busy after start", busy, 1);
    fork
      begin
        repeat (30) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    join_none
    send_byte(8'h01, 0, 0, 0);
    send_byte(8'h80, 0, 1, 0);
    send_byte(8'h3C, 0, 2, 0);
    send_byte(8'hD2, 1, 3, 0);
    wait_idle();
    check(done_ok == 1 && crc_error == 0 && timeout == 0, "R6 done_ok", {done_ok, crc_error, timeout}, 3'b100);
    check(exp_q.size() == 0, "R3 all LSB bits sent", exp_q.size(), 0);
    check(last_prog == PROG, "R2 prog width", last_prog, PROG);
    check(bad_rise == 0, "R2 no edge before init", bad_rise, 0);
    check(hi_bad == 0, "R4 high phase length", hi_bad, 0);
    check(tail_bad == 0 && tail_rises >= 3, "R6 tail din held", tail_bad, 0);
    check(prog_falls == 1, "R9 start ignored while busy", prog_falls, 1);
    repeat (40) @(negedge clk);
    check(done_ok == 1 && busy == 0, "R9 result held", {busy, done_ok}, 2'b01);

    // MSB first
    begin_load(1'b1, 1'b0, 0, 0);
    send_byte(8'h01, 0, 0, 1);
    send_byte(8'hE4, 0, 1, 1);
    send_byte(8'h5A, 1, 2, 1);
    wait_idle();
    check(done_ok == 1, "R6 done_ok msb", done_ok, 1);
    check(exp_q.size() == 0, "R3 all MSB bits sent", exp_q.size(), 0);
    check(hi_bad == 0, "R4 high phase msb", hi_bad, 0);

    // init low in the middle of the second byte
    begin_load(1'b0, 1'b0, 10, -1);
    send_byte(8'hFF, 0, 0, 0);
    send_byte(8'h0F, 1, 1, 0);
    wait_idle();
    check(crc_error == 1 && done_ok == 0 && timeout == 0, "R7 crc result", {done_ok, crc_error, timeout}, 3'b010);
    check(rises < 16, "R7 load aborted", rises, 15);

    // no done: exact tail length before timeout
    begin_load(1'b1, 1'b0, 0, -1);
    send_byte(8'hA7, 0, 0, 1);
    send_byte(8'h1B, 1, 1, 1);
    wait_idle();
    check(timeout == 1 && done_ok == 0 && crc_error == 0, "R8 tail timeout", {done_ok, crc_error, timeout}, 3'b001);
    check(rises == 16 + TAIL, "R8 tail edge count", rises, 16 + TAIL);
    check(tail_bad == 0, "R6 din held in tail", tail_bad, 0);

    // init never released
    begin_load(1'b0, 1'b1, 0, -1);
    wait_idle();
    check(timeout == 1, "R2 init wait timeout", timeout, 1);
    check(rises == 0 && rdy_seen == 0, "R2 no data without init", rises + rdy_seen, 0);

    // restart clears the old result
    begin_load(1'b0, 1'b0, 0, 1);
    check(busy == 1 && timeout == 0, "R9 result cleared by start", {busy, timeout}, 2'b10);
    send_byte(8'h96, 1, 0, 0);
    wait_idle();
    check(done_ok == 1 && exp_q.size() == 0, "R6 single byte load", done_ok, 1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule